// File: doc/BRIEF.md
# I2C Passive Bus Monitor

This block listens to the clock and data wires of a two-wire I2C bus from inside the system clock domain and turns the activity it sees into a stream of decoded bus events. It never drives either wire. Both lines are oversampled: each one passes through a synchroniser, and edges are found by comparing the synchronised level with its value one clock earlier.

A four-state decoder (waiting for a START, collecting the address byte, waiting for a data byte, sampling the acknowledge bit) turns those edges into events. Each event is a one-cycle pulse that carries a 4-bit kind code and an 8-bit value. The read/write direction taken from the address byte is kept and applied to every data byte that follows. A START that arrives before any STOP is marked as a repeated START. If the state register ever holds an encoding outside the four legal ones, the decoder raises an error pulse and falls back to waiting for a START.

Typical uses are bus tracing, protocol checking and triggering on chosen transfers, all without loading the bus.

Top module: `i2c_bus_watch`

## Requirements
- R1: When the monitor is idle, a falling SDA while SCL stays high is a START. It produces an event of kind 0 with value 0, or kind 1 if the repeated flag is set, and the decoder moves on to collect the address byte.
- R2: When the monitor is idle, nothing except a START produces an event: SCL pulses, SDA changes while SCL is low, and STOP conditions all leave the output quiet.
- R3: The address byte is taken MSB first, one bit on each of 8 rising SCL edges. On the 8th edge the monitor reports kind 5 if the byte's LSB is 1 (read) or kind 6 if the LSB is 0 (write). The value is the byte shifted right by one when ADDR_SHIFT=1, and the full byte when ADDR_SHIFT=0.
- R4: The rising SCL edge after any byte samples the acknowledge bit. SDA low gives kind 3 (ACK) and SDA high gives kind 4 (NACK), both with value 0. The decoder then waits for a data byte.
- R5: A data byte is 8 rising SCL edges, MSB first. It is reported with its value as kind 7 if the latched direction is read, or kind 8 if it is write. The direction latched from the address byte holds until the next address byte.
- R6: START and STOP conditions are recognised only while the decoder waits for a data byte. During the address byte or the acknowledge bit, an SDA edge while SCL is high is ignored, but rising SCL edges still count as bits.
- R7: While waiting for a data byte, a STOP reports kind 2 with value 0, throws away any partly collected byte and returns the monitor to idle. A START in the same state reports kind 1 and begins a new address byte.
- R8: A START seen with no STOP since the previous START is reported as kind 1. A STOP clears this flag, so the next START is reported as kind 0.
- R9: Every event is a single-cycle ev_valid_o pulse with the kind on ev_type_o and the value on ev_data_o. The value is zero for kinds 0 to 4.
- R10: err_o is low after reset and stays low while the state register holds one of its four legal encodings. An illegal encoding pulses err_o and sends the decoder back to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Observed bus clock line (asynchronous) |
| sda_i | input | 1 | Observed bus data line (asynchronous) |
| ev_valid_o | output | 1 | One-cycle pulse marking a decoded event |
| ev_type_o | output | 4 | Event kind code (0 to 8) |
| ev_data_o | output | DATA_W (8) | Address or data byte; zero for condition and acknowledge events |
| err_o | output | 1 | Pulse on an illegal decoder state encoding |

## Verification
The main decode path is driven from a table of transfers. The rows cover both directions, zero, one and two data bytes, NACK on the address and on a data byte, endings by STOP and by repeated START, and the all-ones and all-zeros address bytes. Together these separate START from repeated START, ACK from NACK, read-tagged from write-tagged data, and a kept direction from one that is refreshed, and they show that a half-collected byte is dropped at a STOP. A second instance built with ADDR_SHIFT=0 receives the same wire activity, which separates the shifted address value from the full one. Directed sequences then show that an idle bus with stray clock pulses and a STOP stays silent, and that a STOP pattern placed inside the address byte is counted only as a data bit.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;

  typedef enum logic [3:0] {
    EV_START   = 4'd0,
    EV_RSTART  = 4'd1,
    EV_STOP    = 4'd2,
    EV_ACK     = 4'd3,
    EV_NACK    = 4'd4,
    EV_ADDR_RD = 4'd5,
    EV_ADDR_WR = 4'd6,
    EV_DATA_RD = 4'd7,
    EV_DATA_WR = 4'd8
  } ev_kind_e;

  // sparse encoding so that illegal values exist and can be caught
  typedef enum logic [2:0] {
    ST_IDLE = 3'b000,
    ST_ADDR = 3'b001,
    ST_DATA = 3'b010,
    ST_ACK  = 3'b100
  } mon_state_e;

endpackage

// File: rtl/i2cw_line_sync.sv
module i2cw_line_sync #(
  parameter int   STAGES   = 2,
  parameter logic IDLE_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic level_o,
  output logic last_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES:0]   tap;
  logic              last_q;

  assign tap = {chain_q, d_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {STAGES{IDLE_LVL}};
      last_q  <= IDLE_LVL;
    end else begin
      chain_q <= tap[STAGES-1:0];
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign level_o = chain_q[STAGES-1];
  assign last_o  = last_q;

endmodule

// File: rtl/i2cw_decoder.sv
module i2cw_decoder
  import i2cw_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter bit ADDR_SHIFT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_now,
  input  logic              scl_was,
  input  logic              sda_now,
  input  logic              sda_was,
  output logic              ev_valid_o,
  output logic [3:0]        ev_type_o,
  output logic [DATA_W-1:0] ev_data_o,
  output logic              err_o
);

  localparam int              CNT_W    = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  mon_state_e        cur_q, nxt;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] sh_q;
  logic              sh_en;
  logic              dir_q, dir_d;
  logic              rep_q, rep_d;
  logic              ev_v_d;
  ev_kind_e          ev_t_d;
  logic [DATA_W-1:0] ev_dat_d;
  logic              err_d;
  logic              ev_v_q;
  logic [3:0]        ev_t_q;
  logic [DATA_W-1:0] ev_dat_q;
  logic              err_q;

  logic              bit_c, start_c, stop_c, last_c;
  logic [DATA_W-1:0] byte_c;

  // edge and condition detection on synchronised levels
  assign bit_c   = scl_now & ~scl_was;
  assign start_c = scl_now & scl_was & sda_was & ~sda_now;
  assign stop_c  = scl_now & scl_was & ~sda_was & sda_now;
  assign byte_c  = {sh_q[DATA_W-2:0], sda_now};
  assign last_c  = (cnt_q == LAST_BIT);

  // next-state process
  always_comb begin
    nxt      = cur_q;
    cnt_d    = cnt_q;
    dir_d    = dir_q;
    rep_d    = rep_q;
    ev_v_d   = 1'b0;
    ev_t_d   = EV_START;
    ev_dat_d = '0;
    err_d    = 1'b0;
    sh_en    = 1'b0;
    case (cur_q)
      ST_IDLE: begin
        if (start_c) begin
          ev_v_d = 1'b1;
          ev_t_d = rep_q ? EV_RSTART : EV_START;
          rep_d  = 1'b1;
          cnt_d  = '0;
          nxt    = ST_ADDR;
        end
      end
      ST_ADDR: begin
        if (bit_c) begin
          sh_en = 1'b1;
          if (last_c) begin
            ev_v_d   = 1'b1;
            dir_d    = byte_c[0];
            ev_t_d   = byte_c[0] ? EV_ADDR_RD : EV_ADDR_WR;
            ev_dat_d = ADDR_SHIFT ? (byte_c >> 1) : byte_c;
            cnt_d    = '0;
            nxt      = ST_ACK;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
      end
      ST_DATA: begin
        if (bit_c) begin
          sh_en = 1'b1;
          if (last_c) begin
            ev_v_d   = 1'b1;
            ev_t_d   = dir_q ? EV_DATA_RD : EV_DATA_WR;
            ev_dat_d = byte_c;
            cnt_d    = '0;
            nxt      = ST_ACK;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end else if (start_c) begin
          ev_v_d = 1'b1;
          ev_t_d = rep_q ? EV_RSTART : EV_START;
          rep_d  = 1'b1;
          cnt_d  = '0;
          nxt    = ST_ADDR;
        end else if (stop_c) begin
          ev_v_d = 1'b1;
          ev_t_d = EV_STOP;
          rep_d  = 1'b0;
          cnt_d  = '0;
          nxt    = ST_IDLE;
        end
      end
      ST_ACK: begin
        if (bit_c) begin
          ev_v_d = 1'b1;
          ev_t_d = sda_now ? EV_NACK : EV_ACK;
          cnt_d  = '0;
          nxt    = ST_DATA;
        end
      end
      default: begin
        err_d = 1'b1;
        rep_d = 1'b0;
        cnt_d = '0;
        nxt   = ST_IDLE;
      end
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q    <= ST_IDLE;
      cnt_q    <= '0;
      sh_q     <= '0;
      dir_q    <= 1'b0;
      rep_q    <= 1'b0;
      ev_v_q   <= 1'b0;
      ev_t_q   <= 4'd0;
      ev_dat_q <= '0;
      err_q    <= 1'b0;
    end else begin
      cur_q  <= nxt;
      cnt_q  <= cnt_d;
      dir_q  <= dir_d;
      rep_q  <= rep_d;
      ev_v_q <= ev_v_d;
      err_q  <= err_d;
      if (sh_en) begin
        sh_q <= byte_c;
      end
      if (ev_v_d) begin
        ev_t_q   <= ev_t_d;
        ev_dat_q <= ev_dat_d;
      end
    end
  end

  assign ev_valid_o = ev_v_q;
  assign ev_type_o  = ev_t_q;
  assign ev_data_o  = ev_dat_q;
  assign err_o      = err_q;

  // R1: a first START always leaves the decoder collecting an address
  a_r1_start_enters_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_v_q && ev_t_q == EV_START) |-> (cur_q == ST_ADDR));

  // R2: idle without a START condition stays silent
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q == ST_IDLE && !start_c) |=> !ev_v_q);

  // R4: an acknowledge report leaves the decoder waiting for data
  a_r4_ack_to_data: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_v_q && (ev_t_q == EV_ACK || ev_t_q == EV_NACK)) |-> (cur_q == ST_DATA));

  // R5: data kind agrees with the latched direction
  a_r5_dir_tag: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_v_q && (ev_t_q == EV_DATA_RD || ev_t_q == EV_DATA_WR))
      |-> ((ev_t_q == EV_DATA_RD) == dir_q));

  // R6: no condition events out of the address or acknowledge phase
  a_r6_cond_in_data_only: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q == ST_ADDR || cur_q == ST_ACK)
      |=> !(ev_v_q && (ev_t_q == EV_STOP || ev_t_q == EV_RSTART)));

  // R8: a STOP report leaves the repeated flag cleared
  a_r8_stop_clears_rep: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_v_q && ev_t_q == EV_STOP) |-> !rep_q);

  // R9: condition and acknowledge events carry a zero value
  a_r9_zero_value: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_v_q && ev_t_q <= EV_NACK) |-> (ev_dat_q == '0));

  // R10: an error pulse leaves the decoder idle
  a_r10_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> (cur_q == ST_IDLE));

endmodule

// File: rtl/i2c_bus_watch.sv
module i2c_bus_watch
  import i2cw_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter bit ADDR_SHIFT  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              ev_valid_o,
  output logic [3:0]        ev_type_o,
  output logic [DATA_W-1:0] ev_data_o,
  output logic              err_o
);

  localparam int N_LINES = 2;
  localparam int LN_SCL  = 0;
  localparam int LN_SDA  = 1;

  logic [1:0]         rst_pipe_q;
  logic               rst_core_n;
  logic [N_LINES-1:0] line_raw, line_now, line_was;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_pipe_q[1];

  assign line_raw[LN_SCL] = scl_i;
  assign line_raw[LN_SDA] = sda_i;

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    i2cw_line_sync #(
      .STAGES  (SYNC_STAGES),
      .IDLE_LVL(1'b1)
    ) u_sync (
      .clk    (clk),
      .rst_n  (rst_core_n),
      .d_i    (line_raw[g]),
      .level_o(line_now[g]),
      .last_o (line_was[g])
    );
  end

  i2cw_decoder #(
    .DATA_W    (DATA_W),
    .ADDR_SHIFT(ADDR_SHIFT)
  ) u_dec (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .scl_now   (line_now[LN_SCL]),
    .scl_was   (line_was[LN_SCL]),
    .sda_now   (line_now[LN_SDA]),
    .sda_was   (line_was[LN_SDA]),
    .ev_valid_o(ev_valid_o),
    .ev_type_o (ev_type_o),
    .ev_data_o (ev_data_o),
    .err_o     (err_o)
  );

endmodule

// File: tb/i2c_bus_watch_tb.sv
module i2c_bus_watch_tb;

  localparam int Q = 4;  // clocks per bus phase

  localparam logic [3:0] K_START = 4'd0, K_RSTART = 4'd1, K_STOP = 4'd2,
                         K_ACK = 4'd3, K_NACK = 4'd4, K_ARD = 4'd5,
                         K_AWR = 4'd6, K_DRD = 4'd7, K_DWR = 4'd8;

  typedef struct packed {
    logic [7:0] addr;
    logic [7:0] d0;
    logic [7:0] d1;
    logic [1:0] nd;
    logic [2:0] nack;  // bit0 address ack, bit1/bit2 data acks
    logic       rs;    // 1: end with repeated START instead of STOP
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{8'hA0, 8'h3C, 8'hFF, 2'd2, 3'b000, 1'b0},
    '{8'hA1, 8'h81, 8'h00, 2'd1, 3'b010, 1'b1},
    '{8'h4E, 8'h00, 8'h00, 2'd1, 3'b001, 1'b1},
    '{8'hFF, 8'h5A, 8'hA5, 2'd2, 3'b100, 1'b0},
    '{8'h00, 8'h00, 8'h00, 2'd0, 3'b000, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       scl_r, sda_r;
  logic       ev_valid, ev_valid_raw, err, err_raw;
  logic [3:0] ev_type, ev_type_raw;
  logic [7:0] ev_data, ev_data_raw;

  int checks = 0;
  int fails  = 0;
  int wide_pulses = 0;
  int err_seen = 0;
  bit done = 1'b0;
  bit model_rep = 1'b0;
  logic prev_valid = 1'b0;

  logic [11:0] got[$], got_r[$], exp_q[$], exp_r[$];

  always #5 clk = ~clk;

  i2c_bus_watch u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_r), .sda_i(sda_r),
    .ev_valid_o(ev_valid), .ev_type_o(ev_type), .ev_data_o(ev_data), .err_o(err)
  );

  i2c_bus_watch #(.ADDR_SHIFT(1'b0)) u_dut_raw (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_r), .sda_i(sda_r),
    .ev_valid_o(ev_valid_raw), .ev_type_o(ev_type_raw), .ev_data_o(ev_data_raw), .err_o(err_raw)
  );

  always @(negedge clk) begin
    if (ev_valid) got.push_back({ev_type, ev_data});
    if (ev_valid_raw) got_r.push_back({ev_type_raw, ev_data_raw});
    if (ev_valid && prev_valid) wide_pulses++;
    prev_valid = ev_valid;
    if (err || err_raw) err_seen++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic hold();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_r = 1'b1; hold();
    scl_r = 1'b1; hold();
    sda_r = 1'b0; hold();
    scl_r = 1'b0; hold();
  endtask

  task automatic send_bit(input logic b);
    sda_r = b;    hold();
    scl_r = 1'b1; hold();
    scl_r = 1'b0; hold();
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
  endtask

  task automatic bus_stop();
    sda_r = 1'b0; hold();
    scl_r = 1'b1; hold();
    sda_r = 1'b1; hold();
  endtask

  task automatic expect_ev(input logic [3:0] t, input logic [7:0] d, input logic [7:0] draw);
    exp_q.push_back({t, d});
    exp_r.push_back({t, draw});
  endtask

  task automatic expect_start();
    expect_ev(model_rep ? K_RSTART : K_START, 8'h00, 8'h00);
    model_rep = 1'b1;
  endtask

  task automatic check_events(input string tag);
    repeat (10) @(negedge clk);
    chk(got.size() == exp_q.size(), {tag, " event count"}, got.size(), exp_q.size());
    for (int i = 0; i < got.size() && i < exp_q.size(); i++)
      chk(got[i] == exp_q[i], {tag, " event kind/value"}, got[i], exp_q[i]);
    chk(got_r.size() == exp_r.size(), {tag, " R3 unshifted count"}, got_r.size(), exp_r.size());
    for (int i = 0; i < got_r.size() && i < exp_r.size(); i++)
      chk(got_r[i] == exp_r[i], {tag, " R3 unshifted kind/value"}, got_r[i], exp_r[i]);
    got.delete(); got_r.delete(); exp_q.delete(); exp_r.delete();
  endtask

  task automatic run_vec(input vec_t v, input int idx);
    logic [7:0] b;
    bus_start();
    expect_start();
    send_byte(v.addr);
    expect_ev(v.addr[0] ? K_ARD : K_AWR, {1'b0, v.addr[7:1]}, v.addr);
    send_bit(v.nack[0]);
    expect_ev(v.nack[0] ? K_NACK : K_ACK, 8'h00, 8'h00);
    for (int k = 0; k < int'(v.nd); k++) begin
      b = (k == 0) ? v.d0 : v.d1;
      send_byte(b);
      expect_ev(v.addr[0] ? K_DRD : K_DWR, b, b);
      send_bit(v.nack[k+1]);
      expect_ev(v.nack[k+1] ? K_NACK : K_ACK, 8'h00, 8'h00);
    end
    if (!v.rs) begin
      bus_stop();
      expect_ev(K_STOP, 8'h00, 8'h00);
      model_rep = 1'b0;
    end
    check_events($sformatf("R1 R4 R5 R7 R8 row %0d", idx));
  endtask

  initial begin
    rst_n = 1'b0;
    scl_r = 1'b1;
    sda_r = 1'b1;
    repeat (4) @(negedge clk);
    chk(ev_valid == 1'b0, "R9 valid low in reset", ev_valid, 0);
    chk(err == 1'b0, "R10 err low in reset", err, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(ev_valid == 1'b0, "R9 valid low after reset", ev_valid, 0);
    chk(err == 1'b0, "R10 err low after reset", err, 0);

    // table of transfers
    for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

    // R2: idle bus activity without START
    scl_r = 1'b0; hold();
    sda_r = 1'b0; hold();
    scl_r = 1'b1; hold();
    sda_r = 1'b1; hold();   // STOP pattern while idle
    scl_r = 1'b0; hold();
    sda_r = 1'b0; hold();
    sda_r = 1'b1; hold();
    scl_r = 1'b1; hold();
    check_events("R2 idle quiet");

    // R6: STOP pattern inside the address byte counts only as a bit
    bus_start();
    expect_start();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    sda_r = 1'b0; hold();
    scl_r = 1'b1; hold();   // 4th bit = 0
    sda_r = 1'b1; hold();   // ignored STOP
    scl_r = 1'b0; hold();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    expect_ev(K_AWR, 8'h55, 8'hAA);
    send_bit(1'b0);
    expect_ev(K_ACK, 8'h00, 8'h00);
    bus_stop();
    expect_ev(K_STOP, 8'h00, 8'h00);
    model_rep = 1'b0;
    check_events("R6 STOP ignored in address");

    chk(wide_pulses == 0, "R9 single-cycle valid", wide_pulses, 0);
    chk(err_seen == 0, "R10 err stays low", err_seen, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule